// File: doc/BRIEF.md
# Configuration Stream Signature Gate

This block sits in front of the device configuration port and decides whether a partial configuration stream may reach it. Every stream opens with a fixed-length signature of the static design it was built for. The gate collects that prefix and compares it with the signature held in the static logic. Only when the two agree does it pass the remaining bytes through, unchanged and in order. When they differ, it consumes and drops the rest of the stream and raises a sticky error. The static design is left running either way.

Two requesters share the gate. A lock grants the port to one of them at a time, so their streams never mix. The lock is given up when the owner's stream has ended and been drained, or when the owner withdraws its request. After a release, a requester that is still waiting takes priority over the one just served. A one-cycle done pulse marks the end of each completed stream.

Top module: `cfg_sig_gate`

## Requirements
- R1: After a synchronous reset, gnt is 0, s_ready is 0, m_valid is 0, err_flag is 0 and done is 0.
- R2: At most one bit of gnt is high. s_ready[i] is high only while gnt[i] is high. Bit 0 of gnt and of each per-requester vector belongs to requester 0, and requester i drives s_data[8*i+7:8*i]. Output bytes of two streams never interleave.
- R3: The grant is cleared at the clock edge where a finished stream's last byte has left the output register, so gnt is 0 in the cycle done is high. When both requesters wait after a release, the one that was not the previous owner is granted. A held grant never moves directly to the other requester.
- R4: The first SIG_BYTES accepted bytes form the signature, most significant byte first. The first byte is compared with EXP_SIG[SIG_BYTES*8-1 -: 8]. No header byte ever appears on the output.
- R5: When the signature matches, every later byte is presented on m_data unchanged and in order, and m_last is set only with the stream's final byte.
- R6: When the signature differs, no byte of the stream is forwarded, the rest of the stream is accepted and dropped up to its last byte, and err_flag is set.
- R7: A stream whose last byte arrives before the header is complete sets err_flag and forwards nothing.
- R8: A stream made of exactly a matching header forwards nothing, leaves err_flag at 0 and ends with a done pulse.
- R9: err_flag stays set until a cycle with err_clr high (write 1 to clear). A later good stream does not clear it.
- R10: Each stream that reaches its last byte produces exactly one done pulse, one cycle wide, after its output has drained.
- R11: While m_valid is high and m_ready is low, m_valid, m_data and m_last hold their values.
- R12: If the owner drops its request in mid-stream, the stream is abandoned without an error, nothing more of it is forwarded, and the next stream's header is collected from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 2 | Ownership request, one bit per requester |
| gnt | output | 2 | Ownership grant, one-hot or zero |
| s_valid | input | 2 | Byte valid per requester |
| s_data | input | 2*DW | Byte per requester, requester i in bits [DW*i +: DW] |
| s_last | input | 2 | Final byte of the stream, per requester |
| s_ready | output | 2 | Byte accepted per requester |
| m_valid | output | 1 | Byte valid toward the configuration port |
| m_data | output | DW | Forwarded byte |
| m_last | output | 1 | Final forwarded byte |
| m_ready | input | 1 | Configuration port accepts the byte |
| err_clr | input | 1 | Clears the error flag when high |
| err_flag | output | 1 | Sticky signature or length error |
| done | output | 1 | One-cycle pulse at the end of a stream |

## Verification
The bench uses a two-byte signature. It sweeps the first header byte through all 256 values with the second held correct, and then the second through all 256 with the first held correct and with pseudo-random output stalls. Only one value in each sweep may open the gate, which shows that every bit of both header bytes is compared and that the byte order matters. Short, header-only and reversed-order streams separate the length and ordering rules from the plain comparison. Contended and abandoned streams show that the lock keeps streams apart, hands ownership over in rotation, and restarts header collection after a withdrawal.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HEADER,
    ST_COMPARE,
    ST_FORWARD,
    ST_DISCARD,
    ST_DONE
  } gate_st_e;
endpackage

// File: rtl/cfg_gate_lock.sv
module cfg_gate_lock (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] req,
  input  logic       can_grant,
  input  logic       end_ev,
  output logic [1:0] gnt
);
  logic pri_q;
  logic held;
  assign held = |(gnt & req);

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt   <= 2'b00;
      pri_q <= 1'b0;
    end else if (gnt != 2'b00) begin
      if (end_ev || !held) begin
        gnt   <= 2'b00;
        pri_q <= ~gnt[1];
      end
    end else if (can_grant && (req != 2'b00)) begin
      if (req[pri_q]) gnt <= pri_q ? 2'b10 : 2'b01;
      else            gnt <= pri_q ? 2'b01 : 2'b10;
    end
  end
endmodule

// File: rtl/cfg_gate_hdr.sv
module cfg_gate_hdr #(
  parameter int DW        = 8,
  parameter int SIG_BYTES = 8,
  parameter logic [SIG_BYTES*DW-1:0] EXP_SIG = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          shift,
  input  logic [DW-1:0] din,
  output logic          cnt_last,
  output logic          match
);
  localparam int SW = SIG_BYTES * DW;
  localparam int CW = $clog2(SIG_BYTES + 1);

  logic [SW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  generate
    if (SIG_BYTES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)        sh_q <= '0;
        else if (shift) sh_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)        sh_q <= '0;
        else if (shift) sh_q <= {sh_q[SW-DW-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (shift)  cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_last = (cnt_q == CW'(SIG_BYTES - 1));
  assign match    = (sh_q == EXP_SIG);
endmodule

// File: rtl/cfg_gate_obuf.sv
module cfg_gate_obuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          lin,
  input  logic          m_ready,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          m_last,
  output logic          free
);
  always_ff @(posedge clk) begin
    if (rst) begin
      m_valid <= 1'b0;
      m_data  <= '0;
      m_last  <= 1'b0;
    end else if (load) begin
      m_valid <= 1'b1;
      m_data  <= din;
      m_last  <= lin;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  assign free = !m_valid || m_ready;
endmodule

// File: rtl/cfg_sig_gate.sv
module cfg_sig_gate
  import cfg_gate_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SIG_BYTES = 8,
  parameter logic [SIG_BYTES*DW-1:0] EXP_SIG = 64'h3C5A_96E1_0F7B_D248
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    req,
  output logic [1:0]    gnt,
  input  logic [1:0]    s_valid,
  input  logic [2*DW-1:0] s_data,
  input  logic [1:0]    s_last,
  output logic [1:0]    s_ready,
  output logic          m_valid,
  output logic [DW-1:0] m_data,
  output logic          m_last,
  input  logic          m_ready,
  input  logic          err_clr,
  output logic          err_flag,
  output logic          done
);
  gate_st_e      st_q, st_d;
  logic          hdr_last_q, hdr_last_d;
  logic          err_q, done_q;
  logic          own, live, sel_valid, sel_last;
  logic [DW-1:0] sel_data;
  logic          core_ready, acc, err_set;
  logic          cnt_last, match, out_free, load, end_ev, can_grant;

  assign own       = gnt[1];
  assign live      = |(gnt & req);
  assign sel_valid = s_valid[own];
  assign sel_last  = s_last[own];
  assign sel_data  = s_data[own*DW +: DW];

  always_comb begin
    case (st_q)
      ST_HEADER:  core_ready = 1'b1;
      ST_FORWARD: core_ready = out_free;
      ST_DISCARD: core_ready = 1'b1;
      default:    core_ready = 1'b0;
    endcase
  end

  assign s_ready   = (gnt & req) & {2{core_ready}};
  assign acc       = live && sel_valid && core_ready;
  assign load      = acc && (st_q == ST_FORWARD);
  assign end_ev    = (st_q == ST_DONE) && !m_valid;
  assign can_grant = (st_q == ST_IDLE) && !m_valid;

  cfg_gate_lock u_lock (
    .clk(clk), .rst(rst), .req(req), .can_grant(can_grant),
    .end_ev(end_ev), .gnt(gnt)
  );

  cfg_gate_hdr #(.DW(DW), .SIG_BYTES(SIG_BYTES), .EXP_SIG(EXP_SIG)) u_hdr (
    .clk(clk), .rst(rst), .clr(st_q == ST_IDLE),
    .shift(acc && (st_q == ST_HEADER)), .din(sel_data),
    .cnt_last(cnt_last), .match(match)
  );

  cfg_gate_obuf #(.DW(DW)) u_obuf (
    .clk(clk), .rst(rst), .load(load), .din(sel_data), .lin(sel_last),
    .m_ready(m_ready), .m_valid(m_valid), .m_data(m_data),
    .m_last(m_last), .free(out_free)
  );

  always_comb begin
    st_d       = st_q;
    hdr_last_d = hdr_last_q;
    err_set    = 1'b0;
    case (st_q)
      ST_IDLE: if (live) st_d = ST_HEADER;
      ST_HEADER: begin
        if (!live) st_d = ST_IDLE;
        else if (acc) begin
          if (cnt_last) begin
            st_d       = ST_COMPARE;
            hdr_last_d = sel_last;
          end else if (sel_last) begin
            err_set = 1'b1;
            st_d    = ST_DONE;
          end
        end
      end
      ST_COMPARE: begin
        if (!live) st_d = ST_IDLE;
        else if (match) st_d = hdr_last_q ? ST_DONE : ST_FORWARD;
        else begin
          err_set = 1'b1;
          st_d    = hdr_last_q ? ST_DONE : ST_DISCARD;
        end
      end
      ST_FORWARD, ST_DISCARD: begin
        if (!live) st_d = ST_IDLE;
        else if (acc && sel_last) st_d = ST_DONE;
      end
      ST_DONE: if (!m_valid) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      hdr_last_q <= 1'b0;
      err_q      <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      st_q       <= st_d;
      hdr_last_q <= hdr_last_d;
      done_q     <= end_ev;
      if (err_set)      err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign err_flag = err_q;
  assign done     = done_q;
endmodule

// File: rtl/cfg_sig_gate_chk.sv
module cfg_sig_gate_chk
  import cfg_gate_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    gnt,
  input logic [1:0]    s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [DW-1:0] m_data,
  input logic          m_last,
  input logic          err_flag,
  input logic          err_clr,
  input logic          done,
  input gate_st_e      st
);
  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  assert_ready_owner_R2: assert property (@(posedge clk) disable iff (rst)
    (s_ready & ~gnt) == 2'b00);

  assert_no_handover_R3: assert property (@(posedge clk) disable iff (rst)
    (gnt != 2'b00) |=> (gnt == 2'b00) || $stable(gnt));

  assert_done_released_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> (gnt == 2'b00));

  assert_hold_stall_R11: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> m_valid && $stable(m_data) && $stable(m_last));

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> err_flag);

  assert_fwd_only_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> ($past(st) == ST_FORWARD));
endmodule

bind cfg_sig_gate cfg_sig_gate_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .gnt(gnt), .s_ready(s_ready), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .m_last(m_last), .err_flag(err_flag),
  .err_clr(err_clr), .done(done), .st(st_q)
);

// File: tb/test_cfg_sig_gate.sv
`timescale 1ns/1ps
module test_cfg_sig_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  req = '0;
  logic [1:0]  gnt;
  logic [1:0]  s_valid = '0;
  logic [15:0] s_data = '0;
  logic [1:0]  s_last = '0;
  logic [1:0]  s_ready;
  logic        m_valid;
  logic [7:0]  m_data;
  logic        m_last;
  logic        m_ready = 1'b1;
  logic        err_clr = 1'b0;
  logic        err_flag;
  logic        done;

  int nchk = 0;
  int nfail = 0;
  int ndone = 0;
  bit bp_en = 1'b0;
  logic [7:0] lf = 8'h5B;
  logic [7:0] ob[$];
  bit         ol[$];

  always #2 clk = ~clk;

  cfg_sig_gate #(.DW(8), .SIG_BYTES(2), .EXP_SIG(16'hA55A)) i_cfg_sig_gate (
    .clk(clk), .rst(rst), .req(req), .gnt(gnt), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready), .m_valid(m_valid),
    .m_data(m_data), .m_last(m_last), .m_ready(m_ready), .err_clr(err_clr),
    .err_flag(err_flag), .done(done)
  );

  always @(negedge clk) begin
    lf      <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    m_ready <= bp_en ? (lf[0] | lf[2]) : 1'b1;
  end

  always @(posedge clk) begin
    if (!rst && m_valid && m_ready) begin
      ob.push_back(m_data);
      ol.push_back(m_last);
    end
    if (!rst && done) ndone++;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic acquire(input int i);
    @(negedge clk); req[i] = 1'b1; #1;
    while (!gnt[i]) begin @(negedge clk); #1; end
  endtask

  task automatic send(input int i, input int n, input logic [63:0] b, input bit fin);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      s_valid[i] = 1'b1;
      s_data[i*8 +: 8] = b[k*8 +: 8];
      s_last[i] = fin && (k == n - 1);
      #1;
      while (!s_ready[i]) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid[i] = 1'b0;
    s_last[i]  = 1'b0;
  endtask

  task automatic finish(input int i);
    #1;
    while (gnt[i]) begin @(negedge clk); #1; end
    req[i] = 1'b0;
  endtask

  task automatic run(input int i, input int n, input logic [63:0] b);
    acquire(i);
    send(i, n, b, 1'b1);
    finish(i);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  initial begin
    #600000;
    nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    int d0;
    int f1;
    logic [7:0] p1, p2;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1 reset state
    chk(gnt == 2'b00, "R1 gnt", gnt, 0);
    chk(s_ready == 2'b00, "R1 s_ready", s_ready, 0);
    chk(!m_valid && !err_flag && !done, "R1 flags", {m_valid, err_flag, done}, 0);

    // R4 R5 R6 R10: sweep first header byte
    for (int v = 0; v < 256; v++) begin
      ob.delete(); ol.delete(); d0 = ndone;
      p1 = 8'(v) ^ 8'hFF; p2 = 8'(v) + 8'd3;
      run(0, 4, {32'h0, p2, p1, 8'h5A, 8'(v)});
      chk(ndone == d0 + 1, "R10 done pulse", ndone - d0, 1);
      if (v == 8'hA5) begin
        chk(ob.size() == 2 && ob[0] == p1 && ob[1] == p2, "R5 payload",
            ob.size() == 2 ? {ob[0], ob[1]} : 16'hFFFF, {p1, p2});
        chk(ol.size() == 2 && !ol[0] && ol[1], "R5 last", ol.size(), 2);
        chk(!err_flag, "R5 no error", err_flag, 0);
      end else begin
        chk(ob.size() == 0, "R6 nothing forwarded", ob.size(), 0);
        chk(err_flag, "R6 error set", err_flag, 1);
        clear_err();
        chk(!err_flag, "R9 clear", err_flag, 0);
      end
    end

    // R4 R11: sweep second header byte under backpressure
    bp_en = 1'b1;
    for (int v = 0; v < 256; v++) begin
      ob.delete(); ol.delete();
      p1 = 8'(v); p2 = ~8'(v);
      run(0, 5, {24'h0, 8'h7E, p2, p1, 8'(v), 8'hA5});
      if (v == 8'h5A) begin
        chk(ob.size() == 3 && ob[0] == p1 && ob[1] == p2 && ob[2] == 8'h7E,
            "R11 payload under stall", ob.size(), 3);
        chk(!err_flag, "R4 second byte match", err_flag, 0);
      end else begin
        chk(ob.size() == 0 && err_flag, "R4 second byte compared", {ob.size(), err_flag}, 1);
        clear_err();
      end
    end
    bp_en = 1'b0;
    repeat (3) @(negedge clk);

    // R4 byte order
    ob.delete();
    run(0, 3, {40'h0, 8'h11, 8'hA5, 8'h5A});
    chk(ob.size() == 0 && err_flag, "R4 reversed order rejected", {ob.size(), err_flag}, 1);
    clear_err();

    // R7 short stream
    ob.delete(); d0 = ndone;
    run(0, 1, 64'hA5);
    chk(ob.size() == 0 && err_flag, "R7 short stream", {ob.size(), err_flag}, 1);
    chk(ndone == d0 + 1, "R10 done after short", ndone - d0, 1);
    clear_err();

    // R8 header only
    ob.delete(); d0 = ndone;
    run(0, 2, 64'h5AA5);
    chk(ob.size() == 0 && !err_flag && ndone == d0 + 1, "R8 header only",
        {ob.size(), err_flag, ndone - d0}, 1);

    // R9 sticky across good stream
    run(0, 3, 64'h33_5A_A4);
    ob.delete();
    run(0, 3, 64'h44_5A_A5);
    chk(err_flag, "R9 sticky", err_flag, 1);
    chk(ob.size() == 1 && ob[0] == 8'h44, "R9 good stream still passes", ob.size(), 1);
    clear_err();
    chk(!err_flag, "R9 cleared", err_flag, 0);

    // R12 abort in header, then header restarts
    ob.delete();
    acquire(0);
    send(0, 1, 64'hA5, 1'b0);
    @(negedge clk); req[0] = 1'b0;
    repeat (2) @(negedge clk);
    chk(gnt == 2'b00 && !err_flag && ob.size() == 0, "R12 abort header",
        {gnt, err_flag, ob.size()}, 0);
    run(0, 3, 64'h77_5A_A5);
    chk(ob.size() == 1 && ob[0] == 8'h77 && !err_flag, "R12 header restarts", ob.size(), 1);

    // R12 abort during forwarding
    ob.delete(); ol.delete();
    acquire(0);
    send(0, 3, 64'h11_5A_A5, 1'b0);
    @(negedge clk); req[0] = 1'b0;
    repeat (3) @(negedge clk);
    chk(ob.size() == 1 && ob[0] == 8'h11 && !ol[0] && !err_flag, "R12 abort forward",
        ob.size(), 1);

    // R2 R3: contention, two rounds
    for (int r = 0; r < 2; r++) begin
      ob.delete();
      fork
        run(0, 4, 64'hC2_C1_5A_A5);
        run(1, 4, 64'hD2_D1_5A_A5);
      join
      chk(ob.size() == 4 && ((ob[0] == 8'hC1 && ob[1] == 8'hC2 && ob[2] == 8'hD1 && ob[3] == 8'hD2) ||
                             (ob[0] == 8'hD1 && ob[1] == 8'hD2 && ob[2] == 8'hC1 && ob[3] == 8'hC2)),
          "R2 no interleave", ob.size(), 4);
      f1 = (ob.size() > 0 && ob[0] == 8'hD1) ? 1 : 0;
      chk(f1 == 1, "R3 rotating priority", f1, 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule